// File: doc/BRIEF.md
# Vector signed widening extender

This unit is a SIMD datapath slice that widens signed integer lanes. It takes a 128-bit source vector, picks either its low or its high 64-bit half, and sign-extends every lane of that half to twice its width. The result fills a full 128-bit vector. A 4-bit size selector chooses the lane width. The selector is decoded by its most significant set bit, so some encodings carry don't-care low bits.

Encodings outside the three legal lane widths raise an error flag in place of a result. The latency does not depend on the operand data. With the default configuration, every output appears exactly one clock after the input strobe. A parameter can remove the output register to give a purely combinational path.

Top module: `vec_sxt_widen`

## Requirements
- R1: With size selector 4'b0001, the eight 8-bit lanes of the chosen half become eight 16-bit result lanes. Each lane is sign-extended by copying its bit 7.
- R2: With a size selector matching 4'b001x, the four 16-bit lanes of the chosen half become four 32-bit result lanes, sign-extended from bit 15.
- R3: With a size selector matching 4'b01xx, the two 32-bit lanes of the chosen half become two 64-bit result lanes, sign-extended from bit 31.
- R4: Half-select 0 takes the lanes from src_i[63:0]. Half-select 1 takes them from src_i[127:64].
- R5: Source lane i of the chosen half lands in result lane i. Lane 0 sits in the least significant bits of both source and result.
- R6: A size selector of 4'b0000, or one matching 4'b1xxx, is reserved. Such an input strobe gives err_o=1, res_valid_o=0 and res_o all zeros.
- R7: With OUT_REG=1 (the default), res_o, res_valid_o and err_o reflect the input exactly one clock after the strobe. A cycle with no strobe yields res_valid_o=0, err_o=0 and res_o all zeros one clock later.
- R8: Asserting rst_ni low clears res_valid_o, err_o and res_o asynchronously. They stay cleared while reset is held, even with a strobe present.
- R9: The extreme lane values widen correctly for every lane width. The most negative value fills the upper half of the wide lane with ones. The most positive value fills it with zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input strobe |
| size_sel_i | input | 4 | Lane-width selector, decoded by its highest set bit |
| upper_half_i | input | 1 | 0: widen the low half, 1: widen the high half |
| src_i | input | 128 | Source vector |
| res_o | output | 128 | Widened result vector, zero unless the result is valid |
| res_valid_o | output | 1 | Result strobe |
| err_o | output | 1 | Reserved-selector error strobe |

## Verification
Random operands for every legal selector value, taken from both halves, separate lane width and half selection from each other. Each legal encoding carries its own don't-care bits, so a wrong leading-bit decode shows up as the wrong width. An operand with lane numbers as lane values exposes any swap or shift in lane order. Alternating most-negative and most-positive lanes expose an extension that copies the wrong bit or zero-fills. Every reserved encoding, idle cycles, and a strobe held during reset confirm that no valid result leaks out and that the result bus stays zero.

// File: rtl/vsx_pkg.sv
package vsx_pkg;
  typedef enum logic [1:0] {
    SZ_B   = 2'd0,
    SZ_H   = 2'd1,
    SZ_W   = 2'd2,
    SZ_RSV = 2'd3
  } sz_e;
  localparam int unsigned NUM_SZ = 3;
endpackage

// File: rtl/vsx_size_dec.sv
module vsx_size_dec
  import vsx_pkg::*;
#(
  parameter int unsigned SEL_W = 4
) (
  input  logic [SEL_W-1:0] sel_i,
  output sz_e              sz_o,
  output logic             rsv_o
);
  // leading set bit picks the lane width; the top bit and all-zero are reserved
  always_comb begin
    sz_o = SZ_RSV;
    if (sel_i[SEL_W-1])      sz_o = SZ_RSV;
    else if (sel_i[2])       sz_o = SZ_W;
    else if (sel_i[1])       sz_o = SZ_H;
    else if (sel_i[0])       sz_o = SZ_B;
    rsv_o = (sz_o == SZ_RSV);
  end
endmodule

// File: rtl/vsx_widen.sv
module vsx_widen
  import vsx_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0] src_i,
  input  logic             upper_i,
  input  sz_e              sz_i,
  output logic [VEC_W-1:0] wide_o
);
  localparam int unsigned HALF_W = VEC_W / 2;

  logic [HALF_W-1:0]             half;
  logic [NUM_SZ-1:0][VEC_W-1:0]  wide;

  assign half = upper_i ? src_i[VEC_W-1:HALF_W] : src_i[HALF_W-1:0];

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_sz
    localparam int unsigned EW = 8 << g;
    localparam int unsigned NE = HALF_W / EW;
    for (genvar e = 0; e < NE; e++) begin : g_lane
      assign wide[g][2*EW*e +: 2*EW] = {{EW{half[EW*e+EW-1]}}, half[EW*e +: EW]};
    end
  end

  always_comb begin
    case (sz_i)
      SZ_B:    wide_o = wide[0];
      SZ_H:    wide_o = wide[1];
      SZ_W:    wide_o = wide[2];
      default: wide_o = '0;
    endcase
  end
endmodule

// File: rtl/vsx_out_stage.sv
module vsx_out_stage #(
  parameter int unsigned VEC_W   = 128,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VEC_W-1:0] res_i,
  input  logic             vld_i,
  input  logic             err_i,
  output logic [VEC_W-1:0] res_o,
  output logic             vld_o,
  output logic             err_o
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_o <= '0;
        vld_o <= 1'b0;
        err_o <= 1'b0;
      end else begin
        res_o <= res_i;
        vld_o <= vld_i;
        err_o <= err_i;
      end
    end
  end else begin : g_comb
    assign res_o = res_i;
    assign vld_o = vld_i;
    assign err_o = err_i;
  end
endmodule

// File: rtl/vec_sxt_widen.sv
module vec_sxt_widen
  import vsx_pkg::*;
#(
  parameter int unsigned VEC_W   = 128,
  parameter int unsigned SEL_W   = 4,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [SEL_W-1:0] size_sel_i,
  input  logic             upper_half_i,
  input  logic [VEC_W-1:0] src_i,
  output logic [VEC_W-1:0] res_o,
  output logic             res_valid_o,
  output logic             err_o
);
  sz_e              sz;
  logic             rsv;
  logic [VEC_W-1:0] wide;
  logic             ok;
  logic             bad;
  logic [VEC_W-1:0] res_d;

  vsx_size_dec #(.SEL_W(SEL_W)) i_dec (
    .sel_i (size_sel_i),
    .sz_o  (sz),
    .rsv_o (rsv)
  );

  vsx_widen #(.VEC_W(VEC_W)) i_widen (
    .src_i   (src_i),
    .upper_i (upper_half_i),
    .sz_i    (sz),
    .wide_o  (wide)
  );

  assign ok    = in_valid_i & ~rsv;
  assign bad   = in_valid_i &  rsv;
  assign res_d = ok ? wide : '0;

  vsx_out_stage #(.VEC_W(VEC_W), .OUT_REG(OUT_REG)) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .res_i  (res_d),
    .vld_i  (ok),
    .err_i  (bad),
    .res_o  (res_o),
    .vld_o  (res_valid_o),
    .err_o  (err_o)
  );
endmodule

// File: rtl/vsx_chk.sv
module vsx_chk #(
  parameter int unsigned VEC_W   = 128,
  parameter int unsigned SEL_W   = 4,
  parameter bit          OUT_REG = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [SEL_W-1:0] size_sel_i,
  input logic             upper_half_i,
  input logic [VEC_W-1:0] src_i,
  input logic [VEC_W-1:0] res_o,
  input logic             res_valid_o,
  input logic             err_o
);
  localparam int unsigned HALF_W = VEC_W / 2;

  assert_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_valid_o && err_o));

  assert_zero_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> res_o == '0);

  if (OUT_REG) begin : g_seq
    assert_rsv_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i && (size_sel_i == '0 || size_sel_i[SEL_W-1]) |=> err_o && !res_valid_o);

    assert_lat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i && size_sel_i != '0 && !size_sel_i[SEL_W-1] |=> res_valid_o && !err_o);

    assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> !res_valid_o && !err_o);

    assert_byte_lo_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i && size_sel_i == 4'b0001 && !upper_half_i |=>
        res_o[15:0] == {{8{$past(src_i[7])}}, $past(src_i[7:0])});

    assert_byte_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i && size_sel_i == 4'b0001 && upper_half_i |=>
        res_o[15:0] == {{8{$past(src_i[HALF_W+7])}}, $past(src_i[HALF_W +: 8])});
  end
endmodule

bind vec_sxt_widen vsx_chk #(.VEC_W(VEC_W), .SEL_W(SEL_W), .OUT_REG(OUT_REG)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .size_sel_i   (size_sel_i),
  .upper_half_i (upper_half_i),
  .src_i        (src_i),
  .res_o        (res_o),
  .res_valid_o  (res_valid_o),
  .err_o        (err_o)
);

// File: tb/test_vec_sxt_widen.sv
`timescale 1ns/1ps
module test_vec_sxt_widen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [3:0]   size_sel = '0;
  logic         upper = 1'b0;
  logic [127:0] src = '0;
  logic [127:0] res;
  logic         res_valid;
  logic         err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vec_sxt_widen i_vec_sxt_widen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .in_valid_i   (in_valid),
    .size_sel_i   (size_sel),
    .upper_half_i (upper),
    .src_i        (src),
    .res_o        (res),
    .res_valid_o  (res_valid),
    .err_o        (err)
  );

  function automatic int lane_w(input logic [3:0] s);
    if (s[3] || s == 4'b0000) return 0;
    if (s[2]) return 32;
    if (s[1]) return 16;
    return 8;
  endfunction

  function automatic logic [127:0] ref_res(input logic [3:0] s, input logic up,
                                           input logic [127:0] v);
    logic [63:0]  h;
    logic [127:0] r;
    int           w;
    h = up ? v[127:64] : v[63:0];
    w = lane_w(s);
    r = '0;
    if (w != 0) begin
      for (int i = 0; i < 64 / w; i++) begin
        for (int b = 0; b < 2 * w; b++) begin
          r[2*w*i + b] = (b < w) ? h[w*i + b] : h[w*i + w - 1];
        end
      end
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one strobe, then sample one clock later
  task automatic apply(input string req, input logic [3:0] s, input logic up,
                       input logic [127:0] v);
    logic legal;
    @(negedge clk);
    in_valid = 1'b1;
    size_sel = s;
    upper    = up;
    src      = v;
    legal    = (lane_w(s) != 0);
    @(posedge clk);
    #1;
    chk(req, "valid", {127'b0, res_valid}, {127'b0, legal});
    chk(req, "err",   {127'b0, err},       {127'b0, ~legal});
    chk(req, "res",   res, ref_res(s, up, v));
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b1;
    size_sel = 4'b0001;
    src      = '1;
    @(posedge clk);
    #1;
    chk("R8", "valid in reset", {127'b0, res_valid}, '0);
    chk("R8", "err in reset",   {127'b0, err},       '0);
    chk("R8", "res in reset",   res,                 '0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b1;
  endtask

  task automatic t_legal_random();
    for (int s = 1; s < 8; s++) begin
      for (int up = 0; up < 2; up++) begin
        for (int k = 0; k < 4; k++) begin
          apply(lane_w(4'(s)) == 8 ? "R1" : lane_w(4'(s)) == 16 ? "R2" : "R3",
                4'(s), 1'(up), rnd128());
        end
      end
    end
  endtask

  task automatic t_halves();
    logic [127:0] v;
    v = {64'h8123_4567_89ab_cdef, 64'h0011_2233_4455_6677};
    apply("R4", 4'b0001, 1'b0, v);
    chk("R4", "low half lane0", {112'b0, res[15:0]}, {112'b0, 16'h0077});
    apply("R4", 4'b0001, 1'b1, v);
    chk("R4", "high half lane0", {112'b0, res[15:0]}, {112'b0, 16'hffef});
  endtask

  task automatic t_order();
    apply("R5", 4'b0001, 1'b0, {64'h0, 64'h0807_0605_0403_0201});
    chk("R5", "byte order", res, 128'h0008_0007_0006_0005_0004_0003_0002_0001);
    apply("R5", 4'b0010, 1'b1, {64'h0004_0003_0002_0001, 64'h0});
    chk("R5", "half order", res, 128'h0000_0004_0000_0003_0000_0002_0000_0001);
  endtask

  task automatic t_extremes();
    apply("R9", 4'b0001, 1'b0, {64'h0, 64'h7f80_7f80_7f80_7f80});
    chk("R9", "byte extremes", res, {4{32'h007f_ff80}});
    apply("R9", 4'b0011, 1'b1, {64'h7fff_8000_7fff_8000, 64'h0});
    chk("R9", "half extremes", res, {2{64'h0000_7fff_ffff_8000}});
    apply("R9", 4'b0111, 1'b0, {64'h0, 64'h7fff_ffff_8000_0000});
    chk("R9", "word extremes", res, {64'h0000_0000_7fff_ffff, 64'hffff_ffff_8000_0000});
  endtask

  task automatic t_reserved();
    apply("R6", 4'b0000, 1'b0, '1);
    for (int s = 8; s < 16; s++) begin
      apply("R6", 4'(s), 1'(s & 1), rnd128() | 128'h1);
    end
  endtask

  task automatic t_idle();
    apply("R7", 4'b0100, 1'b0, rnd128());
    @(negedge clk);
    in_valid = 1'b0;
    size_sel = 4'b0001;
    src      = '1;
    @(posedge clk);
    #1;
    chk("R7", "idle valid", {127'b0, res_valid}, '0);
    chk("R7", "idle err",   {127'b0, err},       '0);
    chk("R7", "idle res",   res,                 '0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_legal_random();
    t_halves();
    t_order();
    t_extremes();
    t_reserved();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule